// File: doc/BRIEF.md
# Threshold-Gated Delay Queue

This block is a single-clock first-in first-out store with valid/ready handshakes on both sides. Its purpose is to act as a fixed-length sample delay line. Incoming words are accepted whenever there is room. Nothing is offered at the output until the store has filled to a compile-time threshold. From then on, words leave in arrival order.

After the gate opens, the queue keeps streaming for as long as it holds data. When it drains completely it arms again and waits once more for the threshold. A typical use sets the threshold to the delay length in samples and the depth to the next power of two. The producer and the consumer then advance together, and every word appears a fixed number of samples after it went in.

A parameter selects whether the output word comes straight from storage or through a register stage. With the register stage, the register holds one word in addition to the store's depth. The threshold and the full condition are counted on the store alone.

Top module: `dlyq_gated`

## Requirements
- R1: Synchronous active-high reset empties the store and arms the gate. In the cycle after reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 0 only while the store holds DEPTH words and no word is leaving it in the same cycle. A write offered at full while a word leaves is accepted.
- R3: While the gate is armed, no word leaves the store until its occupancy is at least THRESH. This holds even when `out_ready` is 1.
- R4: Once words start leaving, the gate stays open, whatever the occupancy, until the store is empty. It then re-arms.
- R5: Every accepted word appears on `out_data` exactly once, in order of acceptance. No word is lost or duplicated.
- R6: With THRESH = 0 and REG_OUT = 0, `out_valid` is 1 in every cycle in which the store is non-empty.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values into the next cycle.
- R8: With REG_OUT = 1, `out_valid` and `out_data` come from a register. The first word appears one cycle after the cycle in which the gate condition is met, and that output register holds one word beyond DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Queue can take a word this cycle |
| in_data | input | DATA_W | Word to store |
| out_valid | output | 1 | `out_data` holds a word for the consumer |
| out_ready | input | 1 | Consumer takes the offered word |
| out_data | output | DATA_W | Oldest word leaving the queue |

## Verification
The hardest situation to reach is a closed gate facing a consumer that is ready while the store holds fewer words than the threshold. That requires a full drain after an earlier open period, followed by a partial refill. The stimulus builds it in phases. It first fills the store with the consumer stalled, which reaches full and exercises back-pressure. It then streams at full with reads and writes in the same cycle, drains to empty, refills below the threshold, and finally offers `out_ready` with no input. A long random phase then follows. A second instance with threshold zero and no output register runs on the same stimulus beside the registered one.

// File: rtl/dlyq_pkg.sv
package dlyq_pkg;

    typedef enum logic {
        GATE_ARMED = 1'b0,
        GATE_OPEN  = 1'b1
    } gate_e;

endpackage

// File: rtl/dlyq_store.sv
module dlyq_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dlyq_ctrl.sv
module dlyq_ctrl
    import dlyq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int THRESH = 48,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ready,
    input  logic              take,
    output logic              push,
    output logic              pop,
    output logic              avail,
    output logic              full,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam logic [PTR_W-1:0] THR_L = PTR_W'(THRESH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        gate_e            gate;
    } ctl_t;

    ctl_t             st_q, st_d;
    logic [PTR_W-1:0] occ, occ_nx;
    logic             empty, reached;

    assign occ = st_q.wr - st_q.rd;

    if (THRESH == 0) begin : g_thr_zero
        assign reached = 1'b1;
    end else begin : g_thr_cmp
        assign reached = (occ >= THR_L);
    end

    always_comb begin
        empty  = (st_q.wr == st_q.rd);
        full   = (st_q.wr[ADDR_W] != st_q.rd[ADDR_W]) &&
                 (st_q.wr[ADDR_W-1:0] == st_q.rd[ADDR_W-1:0]);
        avail  = !empty && ((st_q.gate == GATE_OPEN) || reached);
        pop    = avail && take;
        push   = in_valid && in_ready;
        st_d.wr = st_q.wr + PTR_W'(push);
        st_d.rd = st_q.rd + PTR_W'(pop);
        occ_nx  = st_d.wr - st_d.rd;
        st_d.gate = ((occ_nx != '0) && avail) ? GATE_OPEN : GATE_ARMED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.wr[ADDR_W-1:0];
    assign rd_addr = st_q.rd[ADDR_W-1:0];

endmodule

// File: rtl/dlyq_outstage.sv
module dlyq_outstage #(
    parameter int DATA_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              avail,
    input  logic              pop,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              out_ready,
    output logic              take,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic              vld;
            logic [DATA_W-1:0] data;
        } ost_t;

        ost_t o_q, o_d;
        logic unused_avail;

        assign unused_avail = avail;
        assign take = !o_q.vld || out_ready;

        always_comb begin
            o_d = o_q;
            if (pop) begin
                o_d.vld  = 1'b1;
                o_d.data = rd_data;
            end else if (out_ready) begin
                o_d.vld = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                o_q <= '0;
            end else begin
                o_q <= o_d;
            end
        end

        assign out_valid = o_q.vld;
        assign out_data  = o_q.data;
    end else begin : g_pass
        logic unused_sig;

        assign unused_sig = pop ^ clk ^ rst;
        assign take      = out_ready;
        assign out_valid = avail;
        assign out_data  = rd_data;
    end

endmodule

// File: rtl/dlyq_gated.sv
module dlyq_gated
    import dlyq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 64,
    parameter int THRESH  = 48,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic              full, pop, push, avail, take;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] rd_data;

    assign in_ready = !full || pop;

    dlyq_ctrl #(
        .DEPTH  (DEPTH),
        .THRESH (THRESH)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .take     (take),
        .push     (push),
        .pop      (pop),
        .avail    (avail),
        .full     (full),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr)
    );

    dlyq_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wr_addr),
        .wdata (in_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    dlyq_outstage #(
        .DATA_W  (DATA_W),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .avail     (avail),
        .pop       (pop),
        .rd_data   (rd_data),
        .out_ready (out_ready),
        .take      (take),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/dlyq_gated_chk.sv
module dlyq_gated_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int THRESH = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              full,
    input logic              pop
);

    int   occ_m;
    logic seen_q;
    int   occ_nx;

    always_comb begin
        occ_nx = occ_m + ((in_valid && in_ready) ? 1 : 0) - (pop ? 1 : 0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_m  <= 0;
            seen_q <= 1'b0;
        end else begin
            occ_m  <= occ_nx;
            seen_q <= (occ_nx != 0) && (seen_q || pop);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready)); // R1

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full); // R2

    AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
        (full && pop && in_valid) |=> full); // R2

    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && (occ_m < THRESH)) |-> !pop); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (occ_m == 0) |-> !pop); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ_m <= DEPTH); // R2

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

endmodule

bind dlyq_gated dlyq_gated_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .THRESH (THRESH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .full      (full),
    .pop       (pop)
);

// File: tb/dlyq_gated_test.sv
module dlyq_gated_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vin = 1'b0;
    logic        rdy = 1'b0;
    logic [15:0] din = '0;

    logic        ir0, ov0, ir1, ov1;
    logic [15:0] od0, od1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlyq_gated #(.DATA_W(16), .DEPTH(16), .THRESH(12), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(vin), .in_ready(ir0), .in_data(din),
        .out_valid(ov0), .out_ready(rdy), .out_data(od0));

    dlyq_gated #(.DATA_W(16), .DEPTH(8), .THRESH(0), .REG_OUT(1'b0)) uut_z (
        .clk(clk), .rst(rst), .in_valid(vin), .in_ready(ir1), .in_data(din),
        .out_valid(ov1), .out_ready(rdy), .out_data(od1));

    int cdep [2] = '{16, 8};
    int cthr [2] = '{12, 0};
    bit creg [2] = '{1'b1, 1'b0};

    logic [15:0] mb [2][64];
    int          mh [2];
    int          mc [2];
    bit          mo [2];
    bit          mov [2];
    logic [15:0] mod [2];
    bit          s_av [2];
    bit          s_po [2];
    bit          s_pu [2];
    bit          hold [2];
    logic [15:0] hdat [2];

    int nchk = 0;
    int nfail = 0;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eval(int k, logic a_ir, logic a_ov, logic [15:0] a_od);
        bit          av, po, irdy, eov;
        logic [15:0] eod;
        av = (mc[k] != 0) && (mo[k] || (mc[k] >= cthr[k]));
        if (creg[k]) begin
            eov = mov[k];
            eod = mod[k];
            po  = av && (!mov[k] || rdy);
        end else begin
            eov = av;
            eod = mb[k][mh[k]];
            po  = av && rdy;
        end
        irdy = (mc[k] < cdep[k]) || po;
        chk(k == 0 ? "R2 in_ready registered inst" : "R2 in_ready thr0 inst",
            {15'b0, a_ir}, {15'b0, irdy});
        chk(k == 0 ? "R3 R4 R8 out_valid registered inst" : "R6 out_valid thr0 inst",
            {15'b0, a_ov}, {15'b0, eov});
        if (eov) chk("R5 out_data order", a_od, eod);
        if (hold[k] && a_ov) chk("R7 data held under stall", a_od, hdat[k]);
        hold[k] = a_ov && !rdy;
        hdat[k] = a_od;
        s_av[k] = av;
        s_po[k] = po;
        s_pu[k] = vin && irdy;
    endtask

    task automatic step(int k);
        logic [15:0] t;
        t = mb[k][mh[k]];
        if (s_po[k]) begin
            mh[k] = (mh[k] + 1) % 64;
            mc[k] = mc[k] - 1;
        end
        if (s_pu[k]) begin
            mb[k][(mh[k] + mc[k]) % 64] = din;
            mc[k] = mc[k] + 1;
        end
        mo[k] = (mc[k] != 0) && s_av[k];
        if (creg[k]) begin
            if (s_po[k]) begin
                mov[k] = 1'b1;
                mod[k] = t;
            end else if (rdy) begin
                mov[k] = 1'b0;
            end
        end
    endtask

    task automatic cyc(bit v, bit r);
        @(negedge clk);
        vin = v;
        rdy = r;
        din = din + 16'd1;
        #1;
        eval(0, ir0, ov0, od0);
        eval(1, ir1, ov1, od1);
        @(posedge clk);
        step(0);
        step(1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        nfail++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            mh[k] = 0; mc[k] = 0; mo[k] = 0; mov[k] = 0; mod[k] = '0; hold[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle outputs right after reset release
        chk("R1 out_valid after reset", {15'b0, ov0}, 16'd0);
        chk("R1 in_ready after reset", {15'b0, ir0}, 16'd1);
        chk("R1 out_valid after reset thr0", {15'b0, ov1}, 16'd0);
        chk("R1 in_ready after reset thr0", {15'b0, ir1}, 16'd1);
        // fill with consumer stalled: threshold gate and full back-pressure
        repeat (30) cyc(1'b1, 1'b0);
        // stream at full with same-cycle read and write
        repeat (40) cyc(1'b1, 1'b1);
        // drain to empty so the gate re-arms
        repeat (30) cyc(1'b0, 1'b1);
        // partial refill below threshold, then a ready consumer and no input
        repeat (6) cyc(1'b1, 1'b0);
        repeat (10) cyc(1'b0, 1'b1);
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            cyc($urandom_range(99) < 70, $urandom_range(99) < 60);
        end
        repeat (40) cyc(1'b0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule